// File: doc/BRIEF.md
# Cursor Control Register Bank

This block holds the five control words of a hardware pointer overlay: the image base offset, the on-screen position, the hotspot offset, and two colours. A bus agent may write 1, 2 or 4 bytes starting at any byte inside a register. The written bytes are merged into the stored 32-bit word, and each register then drops the bits it does not implement. Reads are combinational. They return the addressed register shifted down by the byte offset and cut to the access width.

A single lock bit is stored in bit 31 of the offset word. The position and hotspot registers expose the same bit as their bit 31, on writes and on reads, so a driver can freeze the pointer through any of the three. The bank raises a one-cycle `redefine` pulse whenever the pointer image must be fetched again: after a change of the base offset or of colour 0, after any colour 1 write, and when the lock is released. No pulse is raised while the lock is held. The bank also outputs the byte address where the image fetch must start. This address is the base offset less the hotspot corrections.

Top module: `cursor_regbank`

## Requirements
- R1: After reset every register, the lock, `rdData` for every mapped register, `redefine` and `srcAddr` are all zero.
- R2: The register is selected by `addr[4:2]`: 0 offset, 1 position, 2 hotspot, 3 colour 0, 4 colour 1. `addr[1:0]` is the starting byte. `size` 0 means 1 byte, 1 means 2 bytes, 2 or 3 means 4 bytes. A write replaces only the bytes from the starting byte up to byte 3 that fall inside the access width. Data bytes that would land above byte 3 are dropped.
- R3: `rdData` equals the selected register shifted right by 8×starting byte, with all bits above the access width cleared.
- R4: The offset register keeps only the bits in 0x87FFFFF0. Bit 31 of this register is the lock bit.
- R5: The position register keeps 0x3FFF0FFF, with X in bits 29:16 and Y in bits 11:0. The hotspot register keeps 0x003F003F, with X in bits 21:16 and Y in bits 5:0. Both colour registers keep 0x00FFFFFF.
- R6: A position or hotspot write is merged with the current lock bit placed at bit 31. If the merged bit 31 is 1, the lock is set. If it is 0 while the lock was set, the lock clears and `redefine` pulses.
- R7: A position or hotspot read whose bytes reach byte 3 has the lock bit ORed into the top bit of the returned width. Narrower reads that stop below byte 3 carry no lock bit.
- R8: An offset write or a colour 0 write pulses `redefine` only if the stored masked value changes.
- R9: A colour 1 write always pulses `redefine`, even when the value does not change.
- R10: `redefine` is high for exactly the one cycle after the write clock edge. It stays low whenever the lock is set after that write.
- R11: `srcAddr` = (offset with bit 31 cleared) − hotspot X − 16×hotspot Y, modulo 2^32.
- R12: Writes to register selections 5 to 7 change nothing and do not pulse. Reads from those selections return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the current address |
| addr | input | 5 | Register select (bits 4:2) and starting byte (bits 1:0) |
| size | input | 2 | Access width code: 0 → 1 byte, 1 → 2 bytes, 2 or 3 → 4 bytes |
| wrData | input | 32 | Write data, right-aligned |
| rdData | output | 32 | Combinational read data for `addr` and `size` |
| redefine | output | 1 | One-cycle image refetch pulse |
| srcAddr | output | 32 | Start address of the pointer image |

## Verification
The bench goes after the lock handling most of all. It sets the lock through a full position write, keeps it through a byte-0 write, releases it through a hotspot write and again through a byte-3 position write, and sets it once more through a byte-3 offset write. A design that dropped the lock merge would unlock on any partial write. A design that ignored the lock would pulse while frozen. Reads at byte 3, at bytes 2–3 and at bytes 0–1 show whether the mirrored lock lands on the top bit of the returned width. Repeated writes of the same value separate the change-only pulse rule of the offset and colour 0 from the unconditional rule of colour 1. A 4-byte write at byte 2 and a colour 0 write to its unimplemented top byte expose lane masks that spill over or ignore the register mask.

// File: rtl/cursor_regbank_pkg.sv
package cursor_regbank_pkg;
  localparam int DATA_W   = 32;
  localparam int BYTES    = DATA_W / 8;
  localparam int NUM_REGS = 5;

  typedef enum logic [2:0] {
    REG_OFFSET = 3'd0,
    REG_POS    = 3'd1,
    REG_HOT    = 3'd2,
    REG_COL0   = 3'd3,
    REG_COL1   = 3'd4
  } regIdx_e;

  // control -> datapath write strobes
  typedef struct packed {
    logic [NUM_REGS-1:0] sel;
    logic [BYTES-1:0]    laneEn;
    logic [DATA_W-1:0]   word;
  } wrStrobe_t;

  // datapath -> control register snapshot
  typedef struct packed {
    logic [DATA_W-1:0] off;
    logic [DATA_W-1:0] pos;
    logic [DATA_W-1:0] hot;
    logic [DATA_W-1:0] col0;
    logic [DATA_W-1:0] col1;
  } regFile_t;
endpackage

// File: rtl/cursor_ctl.sv
module cursor_ctl
  import cursor_regbank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wrData,
  input  regFile_t          regs,
  output wrStrobe_t         strb,
  output logic [DATA_W-1:0] rdData
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [1:0]       byteOff;
  logic [2:0]       nBytes;
  logic [3:0]       endByte;
  logic             coversTop;

  assign idx       = addr[ADDR_W-1:2];
  assign byteOff   = addr[1:0];
  assign nBytes    = (size == 2'd0) ? 3'd1 : (size == 2'd1) ? 3'd2 : 3'd4;
  assign endByte   = {2'b00, byteOff} + {1'b0, nBytes};
  assign coversTop = (endByte >= 4'd4);

  // one select line per register
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
    assign strb.sel[r] = wrEn && (idx == IDX_W'(r));
  end

  // byte lanes touched by the access
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign strb.laneEn[b] = (4'(b) >= {2'b00, byteOff}) && (4'(b) < endByte);
  end

  assign strb.word = wrData << {byteOff, 3'b000};

  // read path
  logic [DATA_W-1:0] selVal;
  logic [DATA_W-1:0] widthMask;
  logic [5:0]        topBit;
  logic              lockMirror;

  always_comb begin
    case (idx)
      IDX_W'(REG_OFFSET): selVal = regs.off;
      IDX_W'(REG_POS):    selVal = regs.pos;
      IDX_W'(REG_HOT):    selVal = regs.hot;
      IDX_W'(REG_COL0):   selVal = regs.col0;
      IDX_W'(REG_COL1):   selVal = regs.col1;
      default:            selVal = '0;
    endcase
  end

  assign widthMask  = (nBytes == 3'd4) ? '1
                    : ((DATA_W'(1) << {nBytes, 3'b000}) - DATA_W'(1));
  assign topBit     = {nBytes, 3'b000} - 6'd1;
  assign lockMirror = coversTop && regs.off[DATA_W-1] &&
                      ((idx == IDX_W'(REG_POS)) || (idx == IDX_W'(REG_HOT)));

  always_comb begin
    rdData = (selVal >> {byteOff, 3'b000}) & widthMask;
    if (lockMirror) rdData = rdData | (DATA_W'(1) << topBit);
  end
endmodule

// File: rtl/cursor_dp.sv
module cursor_dp
  import cursor_regbank_pkg::*;
#(
  parameter logic [31:0] OFF_MASK    = 32'h87FF_FFF0,
  parameter logic [31:0] POS_MASK    = 32'h3FFF_0FFF,
  parameter logic [31:0] HOT_MASK    = 32'h003F_003F,
  parameter logic [31:0] COL_MASK    = 32'h00FF_FFFF,
  parameter int          HOT_Y_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strb,
  output regFile_t          regs,
  output logic              redefine,
  output logic [DATA_W-1:0] srcAddr
);
  localparam logic [DATA_W-1:0] LOCK_BIT = DATA_W'(1) << (DATA_W - 1);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] offQ, posQ, hotQ, col0Q, col1Q;
  logic              lockQ;
  logic [DATA_W-1:0] byteMask;

  for (genvar b = 0; b < BYTES; b++) begin : g_bmask
    assign byteMask[8*b +: 8] = {8{strb.laneEn[b]}};
  end

  function automatic logic [DATA_W-1:0] mergeLanes(input logic [DATA_W-1:0] old);
    return (old & ~byteMask) | (strb.word & byteMask);
  endfunction

  logic [DATA_W-1:0] offNew, posT, hotT, col0New, col1New;
  logic              lockNext, redefRaw;

  assign lockQ   = offQ[DATA_W-1];
  assign offNew  = mergeLanes(offQ) & OFF_MASK;
  assign posT    = mergeLanes(posQ | (lockQ ? LOCK_BIT : '0));
  assign hotT    = mergeLanes(hotQ | (lockQ ? LOCK_BIT : '0));
  assign col0New = mergeLanes(col0Q) & COL_MASK;
  assign col1New = mergeLanes(col1Q) & COL_MASK;

  always_comb begin
    lockNext = lockQ;
    redefRaw = 1'b0;
    if (strb.sel[REG_OFFSET]) begin
      lockNext = offNew[DATA_W-1];
      redefRaw = (offNew != offQ);
    end
    if (strb.sel[REG_POS]) begin
      lockNext = posT[DATA_W-1];
      redefRaw = !posT[DATA_W-1] && lockQ;
    end
    if (strb.sel[REG_HOT]) begin
      lockNext = hotT[DATA_W-1];
      redefRaw = !hotT[DATA_W-1] && lockQ;
    end
    if (strb.sel[REG_COL0]) redefRaw = (col0New != col0Q);
    if (strb.sel[REG_COL1]) redefRaw = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offQ     <= '0;
      posQ     <= '0;
      hotQ     <= '0;
      col0Q    <= '0;
      col1Q    <= '0;
      redefine <= 1'b0;
    end else begin
      redefine <= redefRaw && !lockNext;
      if (strb.sel[REG_OFFSET]) offQ <= offNew;
      else                      offQ <= {lockNext, offQ[DATA_W-2:0]};
      if (strb.sel[REG_POS])  posQ  <= posT & POS_MASK;
      if (strb.sel[REG_HOT])  hotQ  <= hotT & HOT_MASK;
      if (strb.sel[REG_COL0]) col0Q <= col0New;
      if (strb.sel[REG_COL1]) col1Q <= col1New;
    end
  end

  assign regs = '{off: offQ, pos: posQ, hot: hotQ, col0: col0Q, col1: col1Q};

  logic [DATA_W-1:0] hotX, hotY;
  assign hotX    = {{HALF{1'b0}}, hotQ[DATA_W-1:HALF]};
  assign hotY    = {{HALF{1'b0}}, hotQ[HALF-1:0]} << HOT_Y_SHIFT;
  assign srcAddr = (offQ & ~LOCK_BIT) - hotX - hotY;

  // R10: no refetch pulse while frozen
  a_r10_no_pulse_locked: assert property (@(posedge clk) disable iff (!rstN)
    redefine |-> !lockQ);
  // R10: a pulse always follows a write
  a_r10_pulse_after_write: assert property (@(posedge clk) disable iff (!rstN)
    redefine |-> $past(|strb.sel));
  // R6: releasing the lock requests a refetch
  a_r6_unlock_pulses: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockQ) |-> redefine);
  // R9: colour 1 writes always refetch unless locked
  a_r9_col1_pulses: assert property (@(posedge clk) disable iff (!rstN)
    strb.sel[REG_COL1] |=> (redefine || lockQ));
  // R8: an offset write that leaves the value unchanged does not refetch
  a_r8_offset_same_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strb.sel[REG_OFFSET] ##1 $stable(offQ) |-> !redefine);
endmodule

// File: rtl/cursor_regbank.sv
module cursor_regbank
  import cursor_regbank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              redefine,
  output logic [31:0]       srcAddr
);
  wrStrobe_t strb;
  regFile_t  regs;

  cursor_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .wrEn   (wrEn),
    .addr   (addr),
    .size   (size),
    .wrData (wrData),
    .regs   (regs),
    .strb   (strb),
    .rdData (rdData)
  );

  cursor_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regs     (regs),
    .redefine (redefine),
    .srcAddr  (srcAddr)
  );
endmodule

// File: tb/cursor_regbank_tb.sv
module cursor_regbank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        redefine;
  logic [31:0] srcAddr;

  cursor_regbank u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .size(size),
    .wrData(wrData), .rdData(rdData), .redefine(redefine), .srcAddr(srcAddr)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    int          kind;  // 0 read data, 1 redefine, 2 source address
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int nCmp = 0;
  int nBad = 0;

  // monitor: compares everything queued, mid-cycle
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? rdData : (it.kind == 1) ? {31'b0, redefine} : srcAddr;
      nCmp++;
      if (act !== it.exp) begin
        nBad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input int idx, input int off, input int sz, input logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; addr = {3'(idx), 2'(off)}; size = 2'(sz); wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input int idx, input int off, input int sz,
                    input logic [31:0] exp, input string tag);
    addr = {3'(idx), 2'(off)}; size = 2'(sz);
    push(0, exp, tag);
    @(posedge clk); #1;
  endtask

  task automatic expRedef(input logic v, input string tag);
    push(1, {31'b0, v}, tag);
  endtask

  task automatic expSrc(input logic [31:0] v, input string tag);
    push(2, v, tag);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    expRedef(1'b0, "R1 redefine at reset");
    expSrc(32'h0, "R1 srcAddr at reset");
    for (int i = 0; i < 5; i++) rd(i, 0, 2, 32'h0, "R1 register zero");

    // R4 R8 offset masking and change pulse
    wr(0, 0, 2, 32'h1234_5678);
    expRedef(1'b1, "R8 offset change pulses");
    rd(0, 0, 2, 32'h0234_5670, "R4 offset mask");
    expRedef(1'b0, "R10 pulse lasts one cycle");
    wr(0, 0, 2, 32'h1234_5678);
    expRedef(1'b0, "R8 same offset no pulse");

    // R2 R3 partial access
    wr(0, 1, 0, 32'h0000_00AB);
    expRedef(1'b1, "R2 byte write changes offset");
    rd(0, 1, 0, 32'h0000_00AB, "R3 byte read");
    rd(0, 2, 1, 32'h0000_0234, "R3 half read");
    wr(0, 2, 2, 32'h1111_0560);
    rd(0, 0, 2, 32'h0560_AB70, "R2 upper bytes dropped");

    // R5 R6 R7 lock via position
    wr(1, 0, 2, 32'hFFFF_FFFF);
    expRedef(1'b0, "R10 locking write no pulse");
    rd(1, 0, 2, 32'hBFFF_0FFF, "R5 R7 position mask and lock mirror");
    rd(0, 0, 2, 32'h8560_AB70, "R6 lock in offset");
    rd(1, 3, 0, 32'h0000_00BF, "R7 byte3 lock");
    rd(1, 2, 1, 32'h0000_BFFF, "R7 half lock");
    rd(1, 0, 1, 32'h0000_0FFF, "R7 low half no lock");

    wr(4, 0, 2, 32'h00AA_BBCC);
    expRedef(1'b0, "R10 col1 while locked no pulse");
    rd(4, 0, 2, 32'h00AA_BBCC, "R5 col1 stored");
    wr(1, 0, 0, 32'h0000_0000);
    expRedef(1'b0, "R6 partial write keeps lock");
    rd(1, 0, 2, 32'hBFFF_0F00, "R6 lock kept");

    // R6 unlock through hotspot, R11 source address
    wr(2, 0, 2, 32'h0005_0003);
    expRedef(1'b1, "R6 hotspot unlock pulses");
    expSrc(32'h0560_AB3B, "R11 source address");
    rd(2, 0, 2, 32'h0005_0003, "R6 hotspot unlocked read");
    rd(0, 0, 2, 32'h0560_AB70, "R6 lock cleared");
    wr(2, 0, 2, 32'h7FFF_7FFF);
    expRedef(1'b0, "R6 no pulse when already unlocked");
    expSrc(32'h0560_A741, "R11 max hotspot");
    rd(2, 0, 2, 32'h003F_003F, "R5 hotspot mask");

    // R8 colour 0
    wr(3, 0, 2, 32'hFF12_3456);
    expRedef(1'b1, "R8 col0 change pulses");
    rd(3, 0, 2, 32'h0012_3456, "R5 col0 mask");
    wr(3, 0, 2, 32'hFF12_3456);
    expRedef(1'b0, "R8 col0 same no pulse");
    wr(3, 3, 0, 32'h0000_0077);
    expRedef(1'b0, "R8 col0 masked byte no pulse");

    // R9 colour 1 same value still pulses
    wr(4, 0, 2, 32'h00AA_BBCC);
    expRedef(1'b1, "R9 col1 repeat pulses");

    // R10 lock via offset byte 3
    wr(0, 3, 0, 32'h0000_0080);
    expRedef(1'b0, "R10 offset lock suppresses pulse");
    expSrc(32'h0060_A741, "R11 lock bit excluded");
    rd(1, 0, 2, 32'hBFFF_0F00, "R7 lock from offset mirrored");

    // unlock via position byte 3
    wr(1, 3, 0, 32'h0000_0012);
    expRedef(1'b1, "R6 position unlock pulses");
    rd(1, 0, 2, 32'h12FF_0F00, "R6 position after unlock");
    rd(0, 0, 2, 32'h0060_AB70, "R6 offset after unlock");

    // R12 unmapped selections
    wr(5, 0, 2, 32'hFFFF_FFFF);
    expRedef(1'b0, "R12 unmapped no pulse");
    rd(5, 0, 2, 32'h0, "R12 unmapped read zero");
    rd(7, 0, 2, 32'h0, "R12 unmapped read zero");
    rd(0, 0, 2, 32'h0060_AB70, "R12 offset untouched");
    rd(4, 0, 2, 32'h00AA_BBCC, "R12 col1 untouched");

    // R2 size code 3 is four bytes
    wr(4, 0, 3, 32'h0102_0304);
    expRedef(1'b1, "R9 col1 pulse");
    rd(4, 0, 3, 32'h0002_0304, "R2 size code 3");
    rd(4, 1, 0, 32'h0000_0003, "R3 byte1 read");

    @(posedge clk); @(posedge clk);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      nBad++;
      nCmp++;
      $display("FAIL watchdog: actual hung expected done");
    end
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule